// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filtering

This block receives asynchronous serial frames from one line shared by many nodes, as on an RS-485 bus. An external tick pulses at sixteen times the bit rate. The block oversamples the line on that tick, confirms each start bit, recovers 8 or 9 data bits plus a stop bit, and stores each frame in a small receive FIFO. A polarity control inverts the line before it is sampled, so the block can take a line that idles low, as some buffers produce.

On a multidrop bus a node only needs to see the frames addressed to it. When the address filter is enabled in 9-bit mode, only frames whose ninth bit is 1 reach the FIFO. Frames whose ninth bit is 0 are dropped without any trace. Once software sees its own address, it turns the filter off so that the data frames that follow are all accepted. Software reads the head entry: the ninth bit and the framing-error flag first, then the data byte. It pulses `readPop` to move to the next entry.

Top module: `mdrop_uart_rx`

## Requirements
- R1: The line is sampled only on cycles where `tick16` is high. The first tick that sees the line low (after polarity correction) is sample 0 of the start bit. The start bit is confirmed by a majority vote of samples 7, 8 and 9. If the vote is high, the pulse is a glitch: no frame is produced and the receiver goes back to waiting for a start bit.
- R2: Each data bit and the stop bit take the majority of samples 7, 8 and 9 of their own 16-tick window. Data bits arrive LSB first. In 8-bit mode (`nineBitMode`=0) the eight bits appear on `rxData` and `rxBit9` reads 0.
- R3: When `invertRx`=1, the line is inverted before any sampling. A line that idles low then carries the same frames as an idle-high line does when `invertRx`=0.
- R4: When `nineBitMode`=1, each frame carries nine data bits. The first eight received appear on `rxData` and the last appears on `rxBit9`.
- R5: When `addrFilterEn`=1 and `nineBitMode`=1, a frame whose ninth bit is 0 is discarded. This holds even if its stop bit is bad. It leaves the FIFO, `rxReady` and the error flags unchanged. A frame whose ninth bit is 1 is stored.
- R6: When `addrFilterEn`=0, every received frame is stored, whatever its ninth bit.
- R7: `rxReady` is high exactly while the FIFO holds at least one entry. `irqReq` is high only when both `rxReady` and `irqEnable` are high.
- R8: A stop bit that votes low stores the frame with `rxFrameErr`=1. That flag belongs to this entry only and is shown while the entry is at the head.
- R9: The FIFO holds two entries in arrival order. `rxData`, `rxBit9` and `rxFrameErr` show the oldest entry. A one-cycle `readPop` pulse removes that entry.
- R10: A frame that would be stored while the FIFO is full sets `overrunErr` and is dropped. While `overrunErr` is set, all further frames are ignored, even after entries have been popped.
- R11: Driving `rxEnable` low clears `overrunErr`, empties the FIFO and ignores the line. Reception starts again once `rxEnable` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxIn | input | 1 | Serial line from the bus |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxEnable | input | 1 | Receive enable; low clears errors and the FIFO |
| nineBitMode | input | 1 | 1 selects 9 data bits per frame |
| addrFilterEn | input | 1 | 1 keeps only frames with ninth bit set (9-bit mode) |
| invertRx | input | 1 | 1 inverts the line before sampling |
| irqEnable | input | 1 | Allows `irqReq` to follow `rxReady` |
| readPop | input | 1 | Removes the head FIFO entry |
| rxData | output | 8 | Data byte of the head entry |
| rxBit9 | output | 1 | Ninth bit of the head entry |
| rxFrameErr | output | 1 | Framing error of the head entry |
| rxReady | output | 1 | FIFO not empty |
| overrunErr | output | 1 | Sticky overrun flag |
| irqReq | output | 1 | Receive interrupt request |

## Verification
The bench sends a short low pulse that fails the mid-bit vote. A receiver that did not vote on the start bit would report a phantom frame of all ones. Address frames and data frames are mixed with the filter on and off, and one filtered frame also has a bad stop bit. A filter that leaked data frames, or that let a dropped frame's framing error through, would change the head entry or `rxReady`. The bench fills the FIFO and then sends two more frames, one of them after a pop. A design that overwrote the head, or that kept receiving once overrun was set, would show the wrong byte or a count different from the model's. The bench also sends a frame with reception disabled and checks that the flush on disable leaves nothing behind.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;

  // Per-cycle strobes from the sampling control to the datapath
  typedef struct packed {
    logic shiftEn;    // one data bit has been voted
    logic shiftBit;   // value of that bit
    logic frameDone;  // stop bit has been voted
    logic stopOk;     // stop bit voted high
  } rxStrobe_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_e;

endpackage

// File: rtl/mdrx_ctrl.sv
module mdrx_ctrl
  import mdrx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxIn,
  input  logic       invertRx,
  input  logic       tick16,
  input  logic       rxEnable,
  input  logic       nineBitMode,
  input  logic       halt,
  output rxStrobe_t  strobe
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] VOTE_A = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] VOTE_B = CNT_W'(OVERSAMPLE / 2);
  localparam logic [CNT_W-1:0] VOTE_C = CNT_W'(OVERSAMPLE / 2 + 1);
  localparam logic [CNT_W-1:0] LAST_T = CNT_W'(OVERSAMPLE - 1);

  logic [1:0]       syncQ;
  logic             lineBit;
  rxState_e         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitIdx;
  logic [1:0]       votes;
  logic             majority;
  logic [BIT_W-1:0] lastBit;
  logic             voteNow;

  // Polarity is corrected ahead of the synchronizer; idle level is 1
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxIn ^ invertRx};
  end
  assign lineBit = syncQ[1];

  assign majority = (votes[1] & votes[0]) | (votes[1] & lineBit) | (votes[0] & lineBit);
  assign lastBit  = nineBitMode ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);
  assign voteNow  = tick16 && (state != RX_IDLE) && (tickCnt == VOTE_C);

  always_comb begin
    strobe = '0;
    if (voteNow && state == RX_DATA) begin
      strobe.shiftEn  = 1'b1;
      strobe.shiftBit = majority;
    end
    if (voteNow && state == RX_STOP) begin
      strobe.frameDone = 1'b1;
      strobe.stopOk    = majority;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      votes   <= 2'b11;
    end else if (!rxEnable || halt) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
    end else if (tick16) begin
      if (state == RX_IDLE) begin
        if (!lineBit) begin
          state   <= RX_START;
          tickCnt <= CNT_W'(1);
        end
      end else begin
        tickCnt <= (tickCnt == LAST_T) ? '0 : tickCnt + 1'b1;
        if (tickCnt == VOTE_A) votes[1] <= lineBit;
        if (tickCnt == VOTE_B) votes[0] <= lineBit;
        if (tickCnt == VOTE_C) begin
          if ((state == RX_START && majority) || state == RX_STOP) state <= RX_IDLE;
        end
        if (tickCnt == LAST_T) begin
          if (state == RX_START) begin
            state  <= RX_DATA;
            bitIdx <= '0;
          end else if (state == RX_DATA) begin
            if (bitIdx == lastBit) state <= RX_STOP;
            else                   bitIdx <= bitIdx + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/mdrx_datapath.sv
module mdrx_datapath
  import mdrx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic              rxEnable,
  input  logic              nineBitMode,
  input  logic              addrFilterEn,
  input  logic              readPop,
  output logic [DATA_W-1:0] headData,
  output logic              headBit9,
  output logic              headFrameErr,
  output logic              notEmpty,
  output logic              overrunErr
);

  localparam int PTR_W   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
  localparam int ENTRY_W = DATA_W + 2;
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FIFO_DEPTH);

  logic [DATA_W:0]      shreg;
  logic [DATA_W-1:0]    frameData;
  logic                 frameBit9;
  logic                 accept, full, push, doPop;
  logic [ENTRY_W-1:0]   mem [FIFO_DEPTH];
  logic [PTR_W-1:0]     wrPtr, rdPtr;
  logic [CNT_W-1:0]     count;

  always_ff @(posedge clk) begin
    if (!rstN)               shreg <= '0;
    else if (strobe.shiftEn) shreg <= {strobe.shiftBit, shreg[DATA_W:1]};
  end

  assign frameData = nineBitMode ? shreg[DATA_W-1:0] : shreg[DATA_W:1];
  assign frameBit9 = nineBitMode & shreg[DATA_W];
  assign accept    = strobe.frameDone && !overrunErr &&
                     !(addrFilterEn && nineBitMode && !frameBit9);
  assign full      = (count == FULL_C);
  assign push      = accept && !full;
  assign doPop     = readPop && (count != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {~strobe.stopOk, frameBit9, frameData};
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      overrunErr <= 1'b0;
    end else begin
      if (push)          wrPtr <= (wrPtr == LAST_P) ? '0 : wrPtr + 1'b1;
      if (doPop)         rdPtr <= (rdPtr == LAST_P) ? '0 : rdPtr + 1'b1;
      if (accept && full) overrunErr <= 1'b1;
      case ({push, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign notEmpty = (count != '0);
  assign {headFrameErr, headBit9, headData} = notEmpty ? mem[rdPtr] : '0;

endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
  import mdrx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic              tick16,
  input  logic              rxEnable,
  input  logic              nineBitMode,
  input  logic              addrFilterEn,
  input  logic              invertRx,
  input  logic              irqEnable,
  input  logic              readPop,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxFrameErr,
  output logic              rxReady,
  output logic              overrunErr,
  output logic              irqReq
);

  rxStrobe_t strobe;

  mdrx_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rxIn        (rxIn),
    .invertRx    (invertRx),
    .tick16      (tick16),
    .rxEnable    (rxEnable),
    .nineBitMode (nineBitMode),
    .halt        (overrunErr),
    .strobe      (strobe)
  );

  mdrx_datapath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .rxEnable     (rxEnable),
    .nineBitMode  (nineBitMode),
    .addrFilterEn (addrFilterEn),
    .readPop      (readPop),
    .headData     (rxData),
    .headBit9     (rxBit9),
    .headFrameErr (rxFrameErr),
    .notEmpty     (rxReady),
    .overrunErr   (overrunErr)
  );

  assign irqReq = rxReady & irqEnable;

endmodule

// File: rtl/mdrop_uart_rx_chk.sv
module mdrop_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              irqEnable,
  input logic              readPop,
  input logic [DATA_W-1:0] rxData,
  input logic              rxBit9,
  input logic              rxFrameErr,
  input logic              rxReady,
  input logic              overrunErr,
  input logic              irqReq
);

  // R11: disabling reception empties the FIFO and clears overrun
  a_r11_disable_flushes: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (!rxReady && !overrunErr));

  // R10: overrun stays set while reception is enabled
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrunErr && rxEnable) |=> overrunErr);

  // R10: overrun can only appear when the FIFO already held data
  a_r10_overrun_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(rxReady));

  // R9: without a pop the FIFO does not drain
  a_r9_ready_held: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !readPop && rxEnable) |=> rxReady);

  // R9: head entry does not move without a pop
  a_r9_head_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !readPop && rxEnable) |=>
      ($stable(rxData) && $stable(rxBit9) && $stable(rxFrameErr)));

  // R7: no interrupt request while the enable is low
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irqReq);

endmodule

bind mdrop_uart_rx mdrop_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxEnable   (rxEnable),
  .irqEnable  (irqEnable),
  .readPop    (readPop),
  .rxData     (rxData),
  .rxBit9     (rxBit9),
  .rxFrameErr (rxFrameErr),
  .rxReady    (rxReady),
  .overrunErr (overrunErr),
  .irqReq     (irqReq)
);

// File: tb/mdrop_uart_rx_tb.sv
module mdrop_uart_rx_tb;

  logic       clk = 1'b0;
  logic       rstN, rxIn, tick16, rxEnable, nineBitMode, addrFilterEn;
  logic       invertRx, irqEnable, readPop;
  logic [7:0] rxData;
  logic       rxBit9, rxFrameErr, rxReady, overrunErr, irqReq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // reference model: entries are {frameErr, bit9, data}
  logic [9:0] expQ[$];
  logic       expOvr = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  mdrop_uart_rx u_dut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .tick16(tick16), .rxEnable(rxEnable),
    .nineBitMode(nineBitMode), .addrFilterEn(addrFilterEn), .invertRx(invertRx),
    .irqEnable(irqEnable), .readPop(readPop), .rxData(rxData), .rxBit9(rxBit9),
    .rxFrameErr(rxFrameErr), .rxReady(rxReady), .overrunErr(overrunErr), .irqReq(irqReq)
  );

  // tick generator: one pulse every 4 clocks
  initial begin
    int div = 0;
    tick16 = 1'b0;
    forever begin
      @(negedge clk);
      div++;
      tick16 = (div % 4 == 0);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare every clock of a quiet window against the model
  task automatic checkState(input string tag);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk({tag, " ready"}, 16'(rxReady), 16'(expQ.size() > 0));
      chk({tag, " overrun"}, 16'(overrunErr), 16'(expOvr));
      chk({tag, " irq"}, 16'(irqReq), 16'((expQ.size() > 0) && irqEnable));
      if (expQ.size() > 0)
        chk({tag, " head"}, 16'({rxFrameErr, rxBit9, rxData}), 16'(expQ[0]));
    end
  endtask

  task automatic holdLevel(input logic lvl);
    rxIn = lvl ^ invertRx;
    repeat (64) @(negedge clk);
  endtask

  task automatic modelFrame(input logic [8:0] val, input int nbits, input logic stopVal);
    logic b9;
    b9 = (nbits == 9) ? val[8] : 1'b0;
    if (!rxEnable || expOvr) return;
    if (addrFilterEn && nbits == 9 && !b9) return;
    if (expQ.size() == 2) expOvr = 1'b1;
    else expQ.push_back({~stopVal, b9, val[7:0]});
  endtask

  task automatic sendFrame(input logic [8:0] val, input int nbits, input logic stopVal);
    holdLevel(1'b0);
    for (int i = 0; i < nbits; i++) holdLevel(val[i]);
    holdLevel(stopVal);
    holdLevel(1'b1);
    holdLevel(1'b1);
    modelFrame(val, nbits, stopVal);
  endtask

  task automatic popOne();
    @(negedge clk) readPop = 1'b1;
    @(negedge clk) readPop = 1'b0;
    if (expQ.size() > 0) void'(expQ.pop_front());
  endtask

  task automatic setEnable(input logic en);
    @(negedge clk) rxEnable = en;
    if (!en) begin expQ.delete(); expOvr = 1'b0; end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; rxIn = 1'b1; rxEnable = 1'b0; nineBitMode = 1'b0;
    addrFilterEn = 1'b0; invertRx = 1'b0; irqEnable = 1'b0; readPop = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    checkState("R7 reset");
    rxEnable = 1'b1;
    repeat (70) @(negedge clk);

    // R2: 8-bit frames, LSB first
    sendFrame(9'h0A5, 8, 1'b1);
    checkState("R2 frame A5");
    popOne();
    sendFrame(9'h03C, 8, 1'b1);
    checkState("R2 frame 3C");
    popOne();
    checkState("R9 empty after pop");

    // R1: short low pulse is rejected at the mid-bit vote
    rxIn = 1'b0;
    repeat (12) @(negedge clk);
    rxIn = 1'b1;
    repeat (160) @(negedge clk);
    checkState("R1 glitch ignored");

    // R3: inverted line, idles low
    @(negedge clk) begin invertRx = 1'b1; rxIn = 1'b0; end
    repeat (70) @(negedge clk);
    sendFrame(9'h05A, 8, 1'b1);
    checkState("R3 inverted frame");
    popOne();
    @(negedge clk) begin invertRx = 1'b0; rxIn = 1'b1; end
    repeat (70) @(negedge clk);

    // R4: 9-bit frames
    nineBitMode = 1'b1;
    sendFrame(9'h123, 9, 1'b1);
    checkState("R4 ninth bit set");
    popOne();
    sendFrame(9'h0FF, 9, 1'b1);
    checkState("R4 ninth bit clear");
    popOne();

    // R5: address filter
    addrFilterEn = 1'b1;
    sendFrame(9'h044, 9, 1'b1);
    checkState("R5 data frame dropped");
    sendFrame(9'h077, 9, 1'b0);
    checkState("R5 bad data frame dropped");
    sendFrame(9'h181, 9, 1'b1);
    checkState("R5 address frame kept");
    popOne();

    // R6: filter off accepts data frames
    addrFilterEn = 1'b0;
    sendFrame(9'h044, 9, 1'b1);
    checkState("R6 data frame kept");
    popOne();
    nineBitMode = 1'b0;

    // R8: framing error tagged per entry
    sendFrame(9'h0C3, 8, 1'b0);
    sendFrame(9'h011, 8, 1'b1);
    checkState("R8 errored head");
    popOne();
    checkState("R8 clean second entry");
    popOne();

    // R9/R10: fill, overrun, halt
    irqEnable = 1'b1;
    sendFrame(9'h0AA, 8, 1'b1);
    sendFrame(9'h0BB, 8, 1'b1);
    checkState("R9 two entries");
    sendFrame(9'h0CC, 8, 1'b1);
    checkState("R10 overrun set");
    popOne();
    sendFrame(9'h0DD, 8, 1'b1);
    checkState("R10 halted after overrun");

    // R11: disable clears, ignores line, re-enable resumes
    setEnable(1'b0);
    checkState("R11 disabled flush");
    sendFrame(9'h0EE, 8, 1'b1);
    checkState("R11 ignored while disabled");
    setEnable(1'b1);
    repeat (70) @(negedge clk);
    sendFrame(9'h099, 8, 1'b1);
    checkState("R11 resumed");
    irqEnable = 1'b0;
    checkState("R7 irq masked");
    popOne();
    checkState("R7 empty");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule